// File: doc/BRIEF.md
# Time-Multiplexed-Output Neuron Layer Engine

This block evaluates one fully connected network layer. Input samples enter one at a time into a tapped delay line of `N_TAPS` stages, and every stage feeds its own signed multiplier. Each multiplier lane owns a private weight store holding `N_OUT` words, one per output neuron. All lanes read the same word index in the same cycle, so a complete inner product over every tap comes out each clock. The `N_OUT` neuron results therefore leave in series, one per cycle, after each new sample.

The weight stores are recirculating rings: a word read for computation is written back at the other end of its ring in the same cycle, and no refresh cycles are spent. Software-side loading writes one word at a time, picked by a row pointer (output neuron) and a column pointer (tap). A split mode cuts the line into `N_SUB` equal sub-windows and gives one inner product per sub-window instead of one grand total. This suits sliding temporal windows. Every result passes through a nonlinearity that suppresses sums below a programmable threshold and caps the excess above it at a programmable ceiling.

Top module: `tmo_layer_engine`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Every tap and every weight word is zero, so a first window computed before any load yields 0 on every lane when `thr` is 0.
- R2: A sample is taken only in a cycle where `in_valid` and `in_ready` are both 1. The newest sample becomes tap 0 and tap i moves to tap i+1. `in_ready` is 0 from the cycle after acceptance until the last result of that window has been registered, and `in_valid` pulses during that time change nothing.
- R3: Each accepted sample yields exactly `N_OUT` results. The first appears (`out_valid`=1) in the cycle after acceptance when no load intervenes. Their `out_idx` values run 0,1,…,`N_OUT`-1 in order, one per cycle, and no further `out_valid` follows until the next acceptance.
- R4: With `split_en`=0 at acceptance, lane 0 (`out_lanes` bits [ACC_W-1:0]) carries the nonlinearity of the sum over every tap i of tap_i × weight[i][out_idx]. Every higher lane is 0.
- R5: With `split_en`=1 at acceptance, lane s (`out_lanes` bits [s·ACC_W +: ACC_W]) carries the nonlinearity of the sum over taps s·N_TAPS/N_SUB to (s+1)·N_TAPS/N_SUB−1. The mode is held for the whole window even if `split_en` changes.
- R6: Inputs and weights are two's-complement signed, and products take all four sign quadrants. The accumulator holds the extreme sum (every tap −128, every weight −32, giving 786432 at default sizes) without wrapping.
- R7: While `wl_en` is 1, the word for neuron `wl_row` in lane `wl_col` takes `wl_data` at the clock edge. No other word changes. A load in the middle of a window takes effect for every result of that window not yet produced.
- R8: Weights persist unchanged across any number of windows without being reloaded.
- R9: Each lane outputs 0 when its signed sum is below the signed `thr`, and otherwise min(sum − `thr`, `cap`), with `cap` unsigned. Both are sampled in the cycle the result is computed.
- R10: While `wl_en` is 1, `in_ready` is 0 and no result is produced in the following cycle. The output sequence resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | IN_W | Signed input sample |
| in_ready | output | 1 | Engine idle and able to take a sample |
| split_en | input | 1 | Sub-window mode, captured at acceptance |
| wl_en | input | 1 | Weight write strobe; stalls computation |
| wl_row | input | ROW_W | Output neuron index of the word written |
| wl_col | input | COL_W | Tap lane of the word written |
| wl_data | input | WT_W | Signed weight value |
| thr | input | ACC_W | Signed threshold of the nonlinearity |
| cap | input | ACC_W | Unsigned ceiling of the nonlinearity |
| out_valid | output | 1 | Result strobe |
| out_idx | output | ROW_W | Output neuron index of the result |
| out_lanes | output | N_SUB·ACC_W | Per-sub-window results; lane 0 holds the full sum in full mode |

## Verification
The bench writes weights in the middle of a window, on rows both already produced and still pending. A ring that mapped the row pointer without its current rotation would corrupt the wrong neuron, and the next results or the next window would disagree. It toggles `split_en` and pulses `in_valid` while a window is running. A design that read the live mode or took a sample while busy would shift the line and garble every following sum. A full load of −32 weights against a line of −128 samples drives the accumulator to its extreme, where an undersized sum would wrap negative and clamp to 0. Thresholds of either sign and small ceilings expose a nonlinearity that compares unsigned or forgets to subtract.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

   // Bits needed to index n entries (at least one).
   function automatic int ptr_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Physical slot of logical word `row` in a ring that has been rotated
   // `offset` times.
   function automatic int ring_slot(input int row, input int offset, input int depth);
      return (row + depth - offset) % depth;
   endfunction

endpackage

// File: rtl/tmo_tap_line.sv
module tmo_tap_line #(
   parameter int N_TAPS = 192,
   parameter int IN_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift,
   input  logic [IN_W-1:0]          din,
   output logic [N_TAPS*IN_W-1:0]   taps
);

   // Tap 0 (lowest bits) is the newest sample.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps <= '0;
      end else if (shift) begin
         taps <= {taps[N_TAPS*IN_W-IN_W-1:0], din};
      end
   end

endmodule

// File: rtl/tmo_weight_ring.sv
module tmo_weight_ring #(
   parameter int DEPTH = 32,
   parameter int WT_W  = 6,
   parameter int PTR_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rot,
   input  logic               wr_en,
   input  logic [PTR_W-1:0]   wr_pos,
   input  logic [WT_W-1:0]    wr_data,
   output logic [WT_W-1:0]    head
);

   logic [WT_W-1:0] ring [DEPTH];

   assign head = ring[0];

   // The word read at the head re-enters at the tail: no refresh cycle needed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) ring[k] <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (wr_pos == PTR_W'(k)) ring[k] <= wr_data;
         end
      end else if (rot) begin
         for (int k = 0; k < DEPTH; k++) ring[k] <= ring[(k + 1) % DEPTH];
      end
   end

endmodule

// File: rtl/tmo_partial_sum.sv
module tmo_partial_sum #(
   parameter int SPAN = 64,
   parameter int IN_W = 8,
   parameter int WT_W = 6,
   parameter int PW   = 20
) (
   input  logic [SPAN*IN_W-1:0]  x_vec,
   input  logic [SPAN*WT_W-1:0]  w_vec,
   output logic signed [PW-1:0]  dot
);

   localparam int PP_W = IN_W + WT_W;

   logic signed [PP_W-1:0] prod [SPAN];

   // Four-quadrant products, one per tap.
   for (genvar i = 0; i < SPAN; i++) begin : g_mul
      logic signed [IN_W-1:0] xs;
      logic signed [WT_W-1:0] ws;
      assign xs      = x_vec[i*IN_W +: IN_W];
      assign ws      = w_vec[i*WT_W +: WT_W];
      assign prod[i] = PP_W'(xs) * PP_W'(ws);
   end

   always_comb begin
      dot = '0;
      for (int i = 0; i < SPAN; i++) dot = dot + PW'(prod[i]);
   end

endmodule

// File: rtl/tmo_clamp_stage.sv
module tmo_clamp_stage #(
   parameter int ACC_W = 22
) (
   input  logic signed [ACC_W-1:0] sum,
   input  logic signed [ACC_W-1:0] thr,
   input  logic        [ACC_W-1:0] cap,
   output logic        [ACC_W-1:0] y
);

   logic signed [ACC_W:0] excess;
   logic signed [ACC_W:0] ceiling;

   assign excess  = (ACC_W+1)'(sum) - (ACC_W+1)'(thr);
   assign ceiling = $signed({1'b0, cap});

   always_comb begin
      if (sum < thr)              y = '0;
      else if (excess > ceiling)  y = cap;
      else                        y = excess[ACC_W-1:0];
   end

endmodule

// File: rtl/tmo_layer_engine.sv
module tmo_layer_engine
   import tmo_pkg::*;
#(
   parameter int N_TAPS = 192,
   parameter int N_OUT  = 32,
   parameter int N_SUB  = 3,
   parameter int IN_W   = 8,
   parameter int WT_W   = 6,
   localparam int ROW_W = ptr_bits(N_OUT),
   localparam int COL_W = ptr_bits(N_TAPS),
   localparam int SPAN  = N_TAPS / N_SUB,
   localparam int PW    = IN_W + WT_W + ptr_bits(SPAN),
   localparam int ACC_W = PW + ptr_bits(N_SUB)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [IN_W-1:0]          in_data,
   output logic                     in_ready,
   input  logic                     split_en,
   input  logic                     wl_en,
   input  logic [ROW_W-1:0]         wl_row,
   input  logic [COL_W-1:0]         wl_col,
   input  logic [WT_W-1:0]          wl_data,
   input  logic [ACC_W-1:0]         thr,
   input  logic [ACC_W-1:0]         cap,
   output logic                     out_valid,
   output logic [ROW_W-1:0]         out_idx,
   output logic [N_SUB*ACC_W-1:0]   out_lanes
);

   // ---------------- elaboration checks ----------------
   if (N_SUB < 1 || (N_TAPS % N_SUB) != 0) begin : g_bad_split
      $error("N_TAPS must divide evenly into N_SUB sub-windows");
   end
   if (N_OUT < 2) begin : g_bad_out
      $error("N_OUT must be at least 2");
   end
   if (IN_W < 2 || WT_W < 2) begin : g_bad_width
      $error("IN_W and WT_W must be at least 2");
   end

   // ---------------- sequencer ----------------
   logic             busy;
   logic             mode_q;
   logic [ROW_W-1:0] seq_idx;
   logic             accept;
   logic             step;
   logic             last;

   assign in_ready = !busy && !wl_en;
   assign accept   = in_valid && in_ready;
   assign step     = busy && !wl_en;
   assign last     = (seq_idx == ROW_W'(N_OUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         mode_q  <= 1'b0;
         seq_idx <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         mode_q  <= split_en;
      end else if (step) begin
         if (last) begin
            busy    <= 1'b0;
            seq_idx <= '0;
         end else begin
            seq_idx <= seq_idx + 1'b1;
         end
      end
   end

   // ---------------- delay line ----------------
   logic [N_TAPS*IN_W-1:0] taps;

   tmo_tap_line #(.N_TAPS(N_TAPS), .IN_W(IN_W)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (accept),
      .din   (in_data),
      .taps  (taps)
   );

   // ---------------- weight rings ----------------
   logic             row_ok;
   logic [ROW_W-1:0] wr_slot;
   logic [N_TAPS*WT_W-1:0] heads;

   assign row_ok  = (int'(wl_row) < N_OUT);
   assign wr_slot = ROW_W'(ring_slot(int'(wl_row), int'(seq_idx), N_OUT));

   for (genvar l = 0; l < N_TAPS; l++) begin : g_lane
      logic hit;
      assign hit = wl_en && row_ok && (wl_col == COL_W'(l));
      tmo_weight_ring #(.DEPTH(N_OUT), .WT_W(WT_W), .PTR_W(ROW_W)) u_ring (
         .clk     (clk),
         .rst_n   (rst_n),
         .rot     (step),
         .wr_en   (hit),
         .wr_pos  (wr_slot),
         .wr_data (wl_data),
         .head    (heads[l*WT_W +: WT_W])
      );
   end

   // ---------------- sub-window sums ----------------
   logic signed [PW-1:0]    part [N_SUB];
   logic signed [ACC_W-1:0] total;

   for (genvar s = 0; s < N_SUB; s++) begin : g_sub
      tmo_partial_sum #(.SPAN(SPAN), .IN_W(IN_W), .WT_W(WT_W), .PW(PW)) u_sum (
         .x_vec (taps [s*SPAN*IN_W +: SPAN*IN_W]),
         .w_vec (heads[s*SPAN*WT_W +: SPAN*WT_W]),
         .dot   (part[s])
      );
   end

   always_comb begin
      total = '0;
      for (int s = 0; s < N_SUB; s++) total = total + ACC_W'(part[s]);
   end

   // ---------------- nonlinearity per lane ----------------
   logic [N_SUB*ACC_W-1:0] lanes_next;

   for (genvar s = 0; s < N_SUB; s++) begin : g_nl
      logic signed [ACC_W-1:0] lane_sum;
      logic        [ACC_W-1:0] lane_y;
      if (s == 0) begin : g_primary
         assign lane_sum = mode_q ? ACC_W'(part[s]) : total;
         assign lanes_next[s*ACC_W +: ACC_W] = lane_y;
      end else begin : g_secondary
         assign lane_sum = ACC_W'(part[s]);
         assign lanes_next[s*ACC_W +: ACC_W] = mode_q ? lane_y : '0;
      end
      tmo_clamp_stage #(.ACC_W(ACC_W)) u_clamp (
         .sum (lane_sum),
         .thr ($signed(thr)),
         .cap (cap),
         .y   (lane_y)
      );
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_lanes <= '0;
      end else begin
         out_valid <= step;
         if (step) begin
            out_idx   <= seq_idx;
            out_lanes <= lanes_next;
         end
      end
   end

endmodule

// File: rtl/tmo_layer_checker.sv
module tmo_layer_checker #(
   parameter int N_OUT = 32,
   parameter int N_SUB = 3,
   parameter int ACC_W = 22,
   parameter int ROW_W = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     split_en,
   input logic                     wl_en,
   input logic [ACC_W-1:0]         cap,
   input logic                     out_valid,
   input logic [ROW_W-1:0]         out_idx,
   input logic [N_SUB*ACC_W-1:0]   out_lanes
);

   logic [ROW_W-1:0] exp_idx;
   logic [ROW_W:0]   pending;
   logic             mode_cap;
   logic             took;

   assign took = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_idx  <= '0;
         pending  <= '0;
         mode_cap <= 1'b0;
      end else begin
         if (out_valid)
            exp_idx <= (exp_idx == ROW_W'(N_OUT - 1)) ? '0 : exp_idx + 1'b1;
         if (took) begin
            pending  <= (ROW_W+1)'(N_OUT);
            mode_cap <= split_en;
         end else if (out_valid) begin
            pending  <= pending - 1'b1;
         end
      end
   end

   // R3: results arrive in ascending index order, wrapping per window
   p_idx_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_idx == exp_idx);

   // R3: never more results than the window owes
   p_no_extra_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> pending != '0);

   // R2: ready only once every result of the window is out
   p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (pending == (ROW_W+1)'(out_valid)));

   // R2: accepting a sample makes the engine busy
   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> !in_ready);

   // R10: loading blocks new samples
   p_load_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wl_en |-> !in_ready);

   // R10: loading stalls result production
   p_load_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wl_en |=> !out_valid);

   if (N_SUB > 1) begin : g_quiet
      // R4: full mode leaves the secondary lanes at zero
      p_full_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !mode_cap) |-> out_lanes[N_SUB*ACC_W-1:ACC_W] == '0);
   end

   for (genvar s = 0; s < N_SUB; s++) begin : g_cap
      // R9: no lane exceeds the ceiling in force when it was computed
      p_cap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_lanes[s*ACC_W +: ACC_W] <= $past(cap));
   end

endmodule

bind tmo_layer_engine tmo_layer_checker #(
   .N_OUT (N_OUT),
   .N_SUB (N_SUB),
   .ACC_W (ACC_W),
   .ROW_W (ROW_W)
) u_chk (.*);

// File: tb/tb_tmo_layer_engine.sv
module tb_tmo_layer_engine;

   localparam int NT   = 192;
   localparam int NO   = 32;
   localparam int NS   = 3;
   localparam int SPAN = NT / NS;
   localparam int ACC  = 22;
   localparam longint CAPMAX = (longint'(1) << ACC) - 1;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic [7:0]      in_data;
   logic            in_ready;
   logic            split_en;
   logic            wl_en;
   logic [4:0]      wl_row;
   logic [7:0]      wl_col;
   logic [5:0]      wl_data;
   logic [ACC-1:0]  thr;
   logic [ACC-1:0]  cap;
   logic            out_valid;
   logic [4:0]      out_idx;
   logic [NS*ACC-1:0] out_lanes;

   always #2 clk = ~clk;   // 250 MHz

   tmo_layer_engine dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .split_en(split_en), .wl_en(wl_en),
      .wl_row(wl_row), .wl_col(wl_col), .wl_data(wl_data), .thr(thr),
      .cap(cap), .out_valid(out_valid), .out_idx(out_idx), .out_lanes(out_lanes)
   );

   int     total = 0;
   int     bad   = 0;
   bit     finished = 0;
   int     x_m [NT];
   int     w_m [NT][NO];
   longint thr_i, cap_i;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint dot(input int lo, input int hi, input int o);
      longint s = 0;
      for (int i = lo; i <= hi; i++) s += longint'(x_m[i]) * longint'(w_m[i][o]);
      return s;
   endfunction

   function automatic longint nl(input longint s);
      longint d;
      if (s < thr_i) return 0;
      d = s - thr_i;
      return (d > cap_i) ? cap_i : d;
   endfunction

   task automatic set_nl(input longint t, input longint c);
      thr_i = t; cap_i = c;
      thr = ACC'(t); cap = ACC'(c);
   endtask

   task automatic put_w(input int row, input int col, input int val);
      wl_en = 1'b1; wl_row = 5'(row); wl_col = 8'(col); wl_data = 6'(val);
      w_m[col][row] = val;
      @(negedge clk);
   endtask

   task automatic load_all(input int mode, input int fixed);
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NO; r++)
            put_w(r, c, (mode == 0) ? fixed : (int'($urandom % 64) - 32));
      wl_en = 1'b0;
   endtask

   task automatic run_window(input int x, input bit split, input bit midload, input bit noise);
      int  got;
      int  cyc;
      longint e;
      longint a;
      while (!in_ready) @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready before sample", in_ready, 1);
      in_valid = 1'b1; in_data = 8'(x); split_en = split;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = NT - 1; i > 0; i--) x_m[i] = x_m[i-1];
      x_m[0] = x;
      chk(in_ready == 1'b0, "R2 busy after accept", in_ready, 0);
      got = 0; cyc = 0;
      while (got < NO && cyc < 300) begin
         if (noise) begin
            split_en = $urandom % 2;
            in_valid = (got >= 3 && got < 6);
            in_data  = 8'($urandom);
         end
         if (out_valid) begin
            chk(out_idx == 5'(got), "R3 index order", out_idx, got);
            for (int s = 0; s < NS; s++) begin
               a = longint'(out_lanes[s*ACC +: ACC]);
               if (split)       e = nl(dot(s*SPAN, s*SPAN + SPAN - 1, got));
               else if (s == 0) e = nl(dot(0, NT - 1, got));
               else             e = 0;
               chk(a == e, split ? "R5/R9 split lane" : "R4/R9 full lane", a, e);
            end
            got++;
            if (midload && got == 12) begin
               in_valid = 1'b0;
               for (int l = 0; l < 3; l++) begin
                  put_w((l == 0) ? 5 : (int'($urandom % NO)), int'($urandom % NT),
                        int'($urandom % 64) - 32);
                  chk(!out_valid && !in_ready, "R10 stall during load",
                      {out_valid, in_ready}, 0);
               end
               wl_en = 1'b0;
            end
         end
         @(negedge clk);
         cyc++;
      end
      in_valid = 1'b0;
      chk(got == NO, "R3 result count", got, NO);
      chk(!out_valid, "R3 no extra result", out_valid, 0);
   endtask

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd7321);
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; split_en = 1'b0;
      wl_en = 1'b0; wl_row = '0; wl_col = '0; wl_data = '0;
      set_nl(0, CAPMAX);
      for (int i = 0; i < NT; i++) begin
         x_m[i] = 0;
         for (int o = 0; o < NO; o++) w_m[i][o] = 0;
      end
      repeat (3) @(negedge clk);
      chk(!out_valid, "R1 no result in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid, "R1 idle after reset", out_valid, 0);
      chk(in_ready, "R1 ready after reset", in_ready, 1);

      // R1: zero weights give zero results
      run_window(77, 1'b0, 1'b0, 1'b0);

      // R7: random weights written through row/column pointers
      load_all(1, 0);

      // directed nonlinearity corners (R9)
      set_nl(0, 5);           run_window(-100, 1'b0, 1'b0, 1'b0);
      set_nl(1 << 20, CAPMAX); run_window(127, 1'b1, 1'b0, 1'b0);
      set_nl(-(1 << 21), CAPMAX); run_window(-128, 1'b0, 1'b0, 1'b0);

      // random windows (R2, R3, R4, R5, R7, R8, R10)
      for (int w = 0; w < 40; w++) begin
         case ($urandom % 4)
            0: set_nl(0, CAPMAX);
            1: set_nl(longint'($urandom % 100000) - 50000, CAPMAX);
            2: set_nl(longint'($urandom % 100000) - 50000, longint'($urandom % 30000));
            default: set_nl(-(1 << 21), CAPMAX);
         endcase
         run_window(int'($urandom % 256) - 128, bit'($urandom % 2),
                    (w % 5) == 2, (w % 3) == 1);
      end

      // R6: extreme accumulation, every tap -128 and every weight -32
      load_all(0, -32);
      set_nl(0, CAPMAX);
      for (int w = 0; w < NT; w++) run_window(-128, 1'b0, 1'b0, 1'b0);
      chk(dot(0, NT - 1, 0) == 786432, "R6 model extreme sum", dot(0, NT - 1, 0), 786432);
      run_window(-128, 1'b1, 1'b0, 1'b0);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule